// File: doc/BRIEF.md
# Per-Line Programmable Input Glitch Filter

This block terminates a bank of general-purpose input lines. Every line is captured two ways. An unfiltered path passes the pin through a two-stage synchroniser. A filtered path samples the pin on both clock edges and accepts a new level only after two consecutive half-cycle samples agree. A small register interface turns the filter of each line on or off, using separate write-only set and clear registers and a readable enable-status register. A pin-data register returns, per line, the filtered level when that line's filter is on and the synchronised level otherwise.

The synchronised levels always leave the block unfiltered on a dedicated output for peripheral logic. The level shown in the pin-data register is also exported, so that change-detection logic sees the filtered value. A clock-enable input stands in for the controller clock. While it is low, every sampling register holds, so the read values freeze at what was last captured. Register writes still take effect while it is low.

Each line's filter is a two-state machine with states FLT_LOW and FLT_HIGH. Transition RISE_OK (FLT_LOW to FLT_HIGH) is taken when the latest falling-edge sample is high and either the current pin or the previous rising-edge sample is also high. Transition FALL_OK (FLT_HIGH to FLT_LOW) is the mirror of it. Otherwise the state holds.

Top module: `gpf_bank`

## Requirements
- R1: After reset all filter-enable bits are 0 and, with pins low, the pin-data register reads 0. The addresses are 0 = enable-set (write-only), 1 = enable-clear (write-only), 2 = enable status and 3 = pin data. Reads of addresses 0 and 1 return 0.
- R2: A write to address 0 sets every enable bit whose data bit is 1. A write to address 1 clears every enable bit whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R3: Each line's filter is selected by its own enable bit (bit i controls line i). Enabling one line does not change how another line is read.
- R4: With a line's filter enabled, a pulse shorter than half a clock period never appears in the pin-data register.
- R5: With a line's filter enabled, a pulse of one clock period or longer always appears in the pin-data register.
- R6: Unfiltered, a pin change shows in the pin-data register at the second rising edge after the change. Filtered, a change that lands just before a rising edge shows one rising edge later (the third). A change that lands just before a falling edge shows at the second.
- R7: raw_lvl_o carries the synchronised level of every line whatever the enable bits are, so a short pulse caught by the synchroniser reaches it even when that line is filtered. det_lvl_o equals the pin-data register value.
- R8: With a line's filter disabled, the pin-data bit follows the synchronised pin level, and a pulse shorter than half a period that spans a rising edge is visible.
- R9: While clk_en is low, the pin-data register, raw_lvl_o and the filter states hold their values, and register writes still update the enable bits. After clk_en returns high, the new pin levels appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; the filter samples on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Sampling enable; low freezes all captured levels |
| pin_i | input | N | Asynchronous input line levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | N | Register write data |
| bus_rdata | output | N | Register read data (combinational on bus_addr) |
| raw_lvl_o | output | N | Synchronised, never-filtered levels for peripherals |
| det_lvl_o | output | N | Per-line selected level for change detection |

## Verification
Random single-line pulses are fired at random offsets from the clock edges. Widths under half a period separate a filter that truly needs two consecutive edge samples from one that needs only one. Widths of one period or more, including those that start just after a falling edge, show that the confirmation in the order rising-then-falling is not lost. Directed level changes placed just before a rising edge and just before a falling edge tell the extra cycle of latency apart from none, each with the filter on and off. A pulse on two lines with one filter enabled shows that the lines are independent and that the raw output stays unfiltered. Random set and clear writes against a bench model of the enable register check that zero bits in the data leave the enable bits unchanged.

// File: rtl/gpf_pkg.sv
package gpf_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_FSET  = 2'd0,
        REG_FCLR  = 2'd1,
        REG_FSTAT = 2'd2,
        REG_PDAT  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        FLT_LOW  = 1'b0,
        FLT_HIGH = 1'b1
    } flt_state_e;
endpackage

// File: rtl/gpf_sync.sv
module gpf_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else if (clk_en) begin
            stg_q <= {stg_q[STAGES-2:0], d};
        end
    end

    assign q = stg_q[LAST];
endmodule

// File: rtl/gpf_line.sv
module gpf_line
    import gpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic pin,
    output logic neg_smp,
    output logic st_high,
    output logic flt_out
);
    logic       neg_q;
    logic       pos_q;
    logic       out_q;
    flt_state_e state_q;
    flt_state_e state_d;

    // Falling-edge sample stage
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
        end else if (clk_en) begin
            neg_q <= pin;
        end
    end

    // Rising-edge sample kept for the rising-then-falling pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= 1'b0;
        end else if (clk_en) begin
            pos_q <= pin;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_LOW;
        end else if (clk_en) begin
            state_q <= state_d;
        end
    end

    // Next state: RISE_OK and FALL_OK need two consecutive agreeing samples
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_LOW:  if (neg_q && (pin || pos_q))   state_d = FLT_HIGH;
            FLT_HIGH: if (!neg_q && (!pin || !pos_q)) state_d = FLT_LOW;
            default:  state_d = FLT_LOW;
        endcase
    end

    // Output register: matches the depth of the synchroniser path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (clk_en) begin
            out_q <= (state_q == FLT_HIGH);
        end
    end

    assign neg_smp = neg_q;
    assign st_high = (state_q == FLT_HIGH);
    assign flt_out = out_q;
endmodule

// File: rtl/gpf_regs.sv
module gpf_regs
    import gpf_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      fen
);
    logic [N-1:0] fen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fen_q <= '0;
        end else if (bus_wr && (bus_addr == REG_FSET)) begin
            fen_q <= fen_q | bus_wdata;
        end else if (bus_wr && (bus_addr == REG_FCLR)) begin
            fen_q <= fen_q & ~bus_wdata;
        end
    end

    assign fen = fen_q;
endmodule

// File: rtl/gpf_bank.sv
module gpf_bank
    import gpf_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en,
    input  logic [N-1:0] pin_i,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [N-1:0] bus_wdata,
    output logic [N-1:0] bus_rdata,
    output logic [N-1:0] raw_lvl_o,
    output logic [N-1:0] det_lvl_o
);
    logic [N-1:0] fen;
    logic [N-1:0] sync_vec;
    logic [N-1:0] flt_vec;
    logic [N-1:0] st_vec;
    logic [N-1:0] neg_vec;
    logic [N-1:0] pdat;

    gpf_regs #(.N(N)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .fen       (fen)
    );

    gpf_sync #(.WIDTH(N), .STAGES(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .d      (pin_i),
        .q      (sync_vec)
    );

    for (genvar i = 0; i < N; i++) begin : g_line
        gpf_line i_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .clk_en  (clk_en),
            .pin     (pin_i[i]),
            .neg_smp (neg_vec[i]),
            .st_high (st_vec[i]),
            .flt_out (flt_vec[i])
        );
    end

    assign pdat = (fen & flt_vec) | (~fen & sync_vec);

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            REG_FSTAT: bus_rdata = fen;
            REG_PDAT:  bus_rdata = pdat;
            default:   bus_rdata = '0;
        endcase
    end

    assign raw_lvl_o = sync_vec;
    assign det_lvl_o = pdat;
endmodule

// File: rtl/gpf_bank_chk.sv
module gpf_bank_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clk_en,
    input logic         bus_wr,
    input logic [1:0]   bus_addr,
    input logic [N-1:0] bus_wdata,
    input logic [N-1:0] fen,
    input logic [N-1:0] sync_vec,
    input logic [N-1:0] st_vec,
    input logic [N-1:0] neg_vec
);
    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> ((fen & $past(bus_wdata)) == $past(bus_wdata)));

    a_r2_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> ((fen & $past(bus_wdata)) == '0));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd1)) |=> $stable(fen));

    a_r4_rise_needs_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vec & ~$past(st_vec) & ~$past(neg_vec)) == '0);

    a_r4_fall_needs_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (~st_vec & $past(st_vec) & $past(neg_vec)) == '0);

    a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(sync_vec) && $stable(st_vec)));
endmodule

bind gpf_bank gpf_bank_chk #(.N(N)) i_gpf_bank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .fen       (fen),
    .sync_vec  (sync_vec),
    .st_vec    (st_vec),
    .neg_vec   (neg_vec)
);

// File: tb/test_gpf_bank.sv
`timescale 1ns/10ps
module test_gpf_bank;
    localparam int unsigned N = 8;
    localparam logic [1:0] A_SET = 2'd0, A_CLR = 2'd1, A_STAT = 2'd2, A_PDAT = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_en = 1'b1;
    logic [N-1:0] pins = '0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = A_PDAT;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] raw_lvl_o;
    logic [N-1:0] det_lvl_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [N-1:0] fen_model = '0;

    always #2.5 clk = ~clk;

    gpf_bank #(.N(N)) i_gpf_bank (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pin_i(pins),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .raw_lvl_o(raw_lvl_o), .det_lvl_o(det_lvl_o)
    );

    function automatic logic [N-1:0] f_apply(input logic [N-1:0] cur, input logic [1:0] a,
                                             input logic [N-1:0] d);
        if (a == A_SET) return cur | d;
        if (a == A_CLR) return cur & ~d;
        return cur;
    endfunction

    function automatic int f_lat(input bit filt, input bit before_rise);
        return (filt && before_rise) ? 3 : 2;
    endfunction

    function automatic bit f_seen(input bit filt, input real w);
        if (!filt) return 1'b1;
        return (w >= 5.0);
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [N-1:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0; bus_addr = A_PDAT;
        fen_model = f_apply(fen_model, a, d);
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [N-1:0] d);
        bus_addr = a; #0.2;
        d = bus_rdata;
        bus_addr = A_PDAT; #0.2;
    endtask

    task automatic measure_lat(input bit before_rise, output int lat);
        logic tgt;
        @(posedge clk);
        #(before_rise ? 4.5 : 2.0);
        pins[2] = ~pins[2];
        tgt = pins[2];
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #1;
            lat++;
            if (bus_rdata[2] == tgt) break;
        end
        repeat (4) @(posedge clk);
    endtask

    task automatic pulse_watch(input int ln, input real off, input real w,
                               output bit sf, output bit sr);
        @(posedge clk);
        #(off);
        pins[ln] = 1'b1;
        #(w);
        pins[ln] = 1'b0;
        sf = 0; sr = 0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            sf |= bus_rdata[ln];
            sr |= raw_lvl_o[ln];
        end
        repeat (4) @(posedge clk);
    endtask

    initial begin
        #250000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] rd;
        int lat;
        bit sf, sr;
        void'($urandom(32'd4242));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk); #1;

        // R1: reset state and write-only reads
        bus_read(A_PDAT, rd); check("R1 pin data after reset", rd, '0);
        bus_read(A_STAT, rd); check("R1 enable status after reset", rd, '0);
        bus_read(A_SET, rd);  check("R1 set register reads zero", rd, '0);
        bus_read(A_CLR, rd);  check("R1 clear register reads zero", rd, '0);

        // R2: random set/clear against model
        for (int it = 0; it < 12; it++) begin
            logic [1:0] a;
            logic [N-1:0] d;
            a = ($urandom_range(0, 1) == 0) ? A_SET : A_CLR;
            d = N'($urandom());
            bus_write(a, d);
            bus_read(A_STAT, rd);
            check("R2 set/clear enable bits", rd, fen_model);
        end
        bus_write(A_SET, '0);
        bus_read(A_STAT, rd); check("R2 zero set data leaves bits", rd, fen_model);
        bus_write(A_CLR, '0);
        bus_read(A_STAT, rd); check("R2 zero clear data leaves bits", rd, fen_model);

        // R6: latency, unfiltered then filtered, both edges and both polarities
        bus_write(A_CLR, '1);
        measure_lat(1'b1, lat); check("R6 unfiltered before rise", N'(lat), N'(f_lat(0, 1)));
        measure_lat(1'b0, lat); check("R6 unfiltered before fall", N'(lat), N'(f_lat(0, 0)));
        bus_write(A_SET, 8'h04);
        measure_lat(1'b1, lat); check("R6 filtered before rise", N'(lat), N'(f_lat(1, 1)));
        measure_lat(1'b0, lat); check("R6 filtered before fall", N'(lat), N'(f_lat(1, 0)));
        measure_lat(1'b1, lat); check("R6 filtered before rise again", N'(lat), N'(f_lat(1, 1)));
        measure_lat(1'b0, lat); check("R6 filtered before fall again", N'(lat), N'(f_lat(1, 0)));
        @(posedge clk); #1;
        check("R7 det level equals pin data", det_lvl_o, bus_rdata);

        // R3/R7/R8: short pulse spanning a rising edge on lines 0 and 1, only line 0 filtered
        bus_write(A_CLR, '1);
        bus_write(A_SET, 8'h01);
        @(posedge clk); #4.05;
        pins[1:0] = 2'b11;
        #1.5;
        pins[1:0] = 2'b00;
        sf = 0; sr = 0;
        begin
            bit s1 = 0;
            for (int k = 0; k < 6; k++) begin
                @(posedge clk); #1;
                sf |= bus_rdata[0];
                sr |= raw_lvl_o[0];
                s1 |= bus_rdata[1];
            end
            check("R3 filtered line 0 rejects", N'(sf), '0);
            check("R8 unfiltered line 1 shows pulse", N'(s1), N'(1));
            check("R7 raw output of filtered line 0", N'(sr), N'(1));
        end
        repeat (4) @(posedge clk);

        // R4/R5: random pulses with the filter on every line
        bus_write(A_SET, '1);
        for (int it = 0; it < 40; it++) begin
            int ln;
            real off, w;
            bit longp;
            ln = $urandom_range(0, N - 1);
            off = 0.05 + 0.1 * $urandom_range(0, 48);
            longp = $urandom_range(0, 1);
            w = longp ? 0.1 * $urandom_range(50, 80) : 0.1 * $urandom_range(3, 22);
            pulse_watch(ln, off, w, sf, sr);
            if (longp) check("R5 pulse of a period or more accepted", N'(sf), N'(f_seen(1, w)));
            else       check("R4 pulse under half a period rejected", N'(sf), N'(f_seen(1, w)));
        end
        // R5 directed: one period starting just after a falling edge
        pulse_watch(5, 2.55, 5.0, sf, sr);
        check("R5 one period after falling edge", N'(sf), N'(1));
        pulse_watch(6, 0.05, 5.0, sf, sr);
        check("R5 one period after rising edge", N'(sf), N'(1));

        // R9: freeze with clk_en low, writes still land
        bus_write(A_CLR, 8'hF0);
        @(posedge clk); #1;
        clk_en = 1'b0;
        pins = '1;
        repeat (5) @(posedge clk); #1;
        bus_read(A_PDAT, rd); check("R9 pin data frozen", rd, '0);
        check("R9 raw frozen", raw_lvl_o, '0);
        bus_write(A_SET, 8'h30);
        bus_read(A_STAT, rd); check("R9 write while frozen", rd, fen_model);
        @(posedge clk); #1;
        clk_en = 1'b1;
        repeat (5) @(posedge clk); #1;
        bus_read(A_PDAT, rd); check("R9 pin data after resume", rd, '1);
        check("R7 raw after resume", raw_lvl_o, '1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule